// File: doc/BRIEF.md
# Code-Region Privileged Memory Router

This block sits on the address side of an 8-bit processor bus and decides, cycle by cycle, which of two memories answers: a fast overlay RAM or the original slow RAM that also holds the screen. The decision depends on the data address and also on where the current instruction's opcode was fetched from. On every cycle in which the opcode-fetch strobe is high, a one-bit privilege flag is loaded from a range decode of the address. That flag then holds for the rest of the instruction.

When shadow mode is on, the overlay RAM takes over the whole overlay window, for code and data alike. The one exception is the screen window. An access there reaches the slow memory only if the instruction doing it was fetched from the privileged code range. Code running anywhere else sees overlay RAM at those addresses.

An interrupt can cause a fetch whose opcode is then thrown away. The flag still loads on that cycle, because the strobe cannot tell such a fetch from a real one.

Top module: `crp_router`

## Requirements
- R1: While `rst_i` is high both selects are low. After reset the privilege flag is clear and shadow mode is off.
- R2: With shadow mode off, every access selects the slow memory (`slow_cs_o`=1, `fast_cs_o`=0).
- R3: `shadow_en_i` is sampled at each rising clock edge. The sampled value governs the selects from the next cycle onward.
- R4: With shadow mode on, an address outside the overlay window selects the slow memory.
- R5: With shadow mode on, an address inside the overlay window but outside the screen window selects the fast memory. This holds for opcode fetches as well as other accesses.
- R6: With shadow mode on, a screen-window address selects the slow memory when the privilege flag is set.
- R7: With shadow mode on, a screen-window address selects the fast memory when the privilege flag is clear.
- R8: At the rising edge that ends a cycle with `opfetch_i`=1, the flag loads 1 if the address lies in the privileged range and 0 otherwise. Cycles with `opfetch_i`=0, such as operand reads from the privileged range, leave it unchanged.
- R9: A fetch that an interrupt later discards still loads the flag as in R8. The interrupt's own stack accesses then route by that flag.
- R10: Outside reset exactly one of `fast_cs_o` and `slow_cs_o` is high in every cycle.
- R11: Every range is inclusive at both ends. With the default parameters the ranges are: privileged 0xC000–0xFFFF, screen 0x3000–0x7FFF, overlay 0x0000–0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opfetch_i | input | 1 | High during an opcode-byte fetch cycle |
| addr_i | input | 16 | Bus address |
| shadow_en_i | input | 1 | Shadow-mode request, registered each cycle |
| fast_cs_o | output | 1 | Select for the fast overlay RAM |
| slow_cs_o | output | 1 | Select for the original slow RAM |

## Verification
The selects are combinational from the current address and the two state bits, so an address change shows in the same cycle. The bench drives inputs on the falling edge and samples a quarter period later, before the next rising edge. A change to the flag or to shadow mode is registered, so it first appears in the cycle after the one that caused it. Each vector's expected selects are therefore worked out from the inputs of earlier vectors, including a discarded fetch followed by stack writes. The reset checks sample during reset and in the two cycles after it, which shows that shadow mode and then the flag were cleared.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef struct packed {
        logic priv;
        logic shadow;
    } ctx_t;

    typedef enum logic [1:0] {
        BANK_NONE = 2'b00,
        BANK_FAST = 2'b01,
        BANK_SLOW = 2'b10
    } bank_e;

endpackage

// File: rtl/crp_range_match.sv
module crp_range_match #(
    parameter int unsigned        AW = 16,
    parameter logic [AW-1:0]      LO = '0,
    parameter logic [AW-1:0]      HI = '1
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] TOP = {AW{1'b1}};
    localparam bit LO_OPEN = (LO == '0);
    localparam bit HI_OPEN = (HI == TOP);

    // The generate branches drop compares that can never fail.
    generate
        if (LO_OPEN && HI_OPEN) begin : g_all
            assign hit_o = 1'b1;
        end else if (LO_OPEN) begin : g_upper
            assign hit_o = (addr_i <= HI);
        end else if (HI_OPEN) begin : g_lower
            assign hit_o = (addr_i >= LO);
        end else begin : g_both
            assign hit_o = (addr_i >= LO) && (addr_i <= HI);
        end
    endgenerate

endmodule

// File: rtl/crp_ctx_reg.sv
module crp_ctx_reg
    import crp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic opfetch_i,
    input  logic priv_hit_i,
    input  logic shadow_en_i,
    output ctx_t ctx_o
);
    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d        = ctx_q;
        ctx_d.shadow = shadow_en_i;
        if (opfetch_i) begin
            ctx_d.priv = priv_hit_i;
        end
        if (rst_i) begin
            ctx_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        ctx_q <= ctx_d;
    end

    assign ctx_o = ctx_q;

    // R8: a fetch cycle loads the decode result.
    p_flag_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        opfetch_i |=> (ctx_q.priv == $past(priv_hit_i)));

    // R8: other cycles leave the flag alone.
    p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !opfetch_i |=> $stable(ctx_q.priv));

    // R3: shadow mode follows the request one cycle later.
    p_shadow_lag_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (ctx_q.shadow == $past(shadow_en_i)));

    // R1: reset clears both state bits.
    p_ctx_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (ctx_q == '0));

endmodule

// File: rtl/crp_bank_sel.sv
module crp_bank_sel
    import crp_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  ctx_t  ctx_i,
    input  logic  ovl_hit_i,
    input  logic  vid_hit_i,
    output bank_e bank_o
);
    always_comb begin
        if (rst_i) begin
            bank_o = BANK_NONE;
        end else if (!ctx_i.shadow || !ovl_hit_i) begin
            bank_o = BANK_SLOW;
        end else if (vid_hit_i && ctx_i.priv) begin
            bank_o = BANK_SLOW;
        end else begin
            bank_o = BANK_FAST;
        end
    end

    // R2: shadow off always means slow memory.
    p_shadow_off_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctx_i.shadow |-> (bank_o == BANK_SLOW));

    // R10: a single bank outside reset.
    p_one_bank_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(bank_o));

endmodule

// File: rtl/crp_router.sv
module crp_router
    import crp_pkg::*;
#(
    parameter int unsigned   AW      = 16,
    parameter logic [AW-1:0] PRIV_LO = 16'hC000,
    parameter logic [AW-1:0] PRIV_HI = 16'hFFFF,
    parameter logic [AW-1:0] VID_LO  = 16'h3000,
    parameter logic [AW-1:0] VID_HI  = 16'h7FFF,
    parameter logic [AW-1:0] OVL_LO  = 16'h0000,
    parameter logic [AW-1:0] OVL_HI  = 16'h7FFF
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          opfetch_i,
    input  logic [AW-1:0] addr_i,
    input  logic          shadow_en_i,
    output logic          fast_cs_o,
    output logic          slow_cs_o
);
    logic  priv_hit, vid_hit, ovl_hit;
    ctx_t  ctx;
    bank_e bank;

    crp_range_match #(.AW(AW), .LO(PRIV_LO), .HI(PRIV_HI)) u_priv_rng (
        .addr_i (addr_i),
        .hit_o  (priv_hit)
    );

    crp_range_match #(.AW(AW), .LO(VID_LO), .HI(VID_HI)) u_vid_rng (
        .addr_i (addr_i),
        .hit_o  (vid_hit)
    );

    crp_range_match #(.AW(AW), .LO(OVL_LO), .HI(OVL_HI)) u_ovl_rng (
        .addr_i (addr_i),
        .hit_o  (ovl_hit)
    );

    crp_ctx_reg u_ctx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .opfetch_i   (opfetch_i),
        .priv_hit_i  (priv_hit),
        .shadow_en_i (shadow_en_i),
        .ctx_o       (ctx)
    );

    crp_bank_sel u_sel (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctx_i     (ctx),
        .ovl_hit_i (ovl_hit),
        .vid_hit_i (vid_hit),
        .bank_o    (bank)
    );

    assign fast_cs_o = (bank == BANK_FAST);
    assign slow_cs_o = (bank == BANK_SLOW);

    // R1: both selects quiet in reset.
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        rst_i |-> (!fast_cs_o && !slow_cs_o));

    // R10: exactly one select out of reset.
    p_exclusive_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        fast_cs_o ^ slow_cs_o);

    // R4: outside the overlay window the slow memory answers.
    p_outside_slow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !ovl_hit |-> slow_cs_o);

    // R6: privileged code reaches real screen memory.
    p_priv_video_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctx.shadow && ovl_hit && vid_hit && ctx.priv) |-> slow_cs_o);

    // R5: non-screen overlay addresses go to the fast memory.
    p_overlay_fast_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctx.shadow && ovl_hit && !vid_hit) |-> fast_cs_o);

    // R7: unprivileged code sees the overlay at screen addresses.
    p_unpriv_video_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctx.shadow && ovl_hit && vid_hit && !ctx.priv) |-> fast_cs_o);

endmodule

// File: tb/crp_router_tb.sv
module crp_router_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        opf;
    logic [15:0] addr;
    logic        shen;
    logic        fast_cs, slow_cs;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crp_router dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .opfetch_i   (opf),
        .addr_i      (addr),
        .shadow_en_i (shen),
        .fast_cs_o   (fast_cs),
        .slow_cs_o   (slow_cs)
    );

    // {req, opfetch, shadow_en, addr, exp_fast, exp_slow}
    localparam logic [24:0] VEC [NV] = '{
        {5'd1 , 1'b1, 1'b1, 16'h1000, 1'b0, 1'b1}, // R1 shadow still off after reset
        {5'd7 , 1'b0, 1'b1, 16'h5000, 1'b1, 1'b0}, // R7 flag clear, screen
        {5'd5 , 1'b0, 1'b1, 16'h1000, 1'b1, 1'b0}, // R5
        {5'd4 , 1'b0, 1'b1, 16'h9000, 1'b0, 1'b1}, // R4
        {5'd4 , 1'b1, 1'b1, 16'hC100, 1'b0, 1'b1}, // R4 fetch from privileged range
        {5'd4 , 1'b0, 1'b1, 16'hC101, 1'b0, 1'b1}, // R4
        {5'd6 , 1'b0, 1'b1, 16'h5000, 1'b0, 1'b1}, // R6
        {5'd5 , 1'b0, 1'b1, 16'h1000, 1'b1, 1'b0}, // R5
        {5'd11, 1'b0, 1'b1, 16'h3000, 1'b0, 1'b1}, // R11 screen lower bound
        {5'd11, 1'b0, 1'b1, 16'h7FFF, 1'b0, 1'b1}, // R11 screen upper bound
        {5'd5 , 1'b1, 1'b1, 16'h2FFF, 1'b1, 1'b0}, // R5 fetch from overlay
        {5'd7 , 1'b0, 1'b1, 16'h5000, 1'b1, 1'b0}, // R7
        {5'd7 , 1'b0, 1'b1, 16'h3000, 1'b1, 1'b0}, // R7
        {5'd4 , 1'b0, 1'b1, 16'hC200, 1'b0, 1'b1}, // R4 operand from priv range
        {5'd8 , 1'b0, 1'b1, 16'h5000, 1'b1, 1'b0}, // R8 operand did not set flag
        {5'd11, 1'b1, 1'b1, 16'hBFFF, 1'b0, 1'b1}, // R11 just below priv start
        {5'd11, 1'b0, 1'b1, 16'h5000, 1'b1, 1'b0}, // R11
        {5'd11, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1}, // R11 priv upper bound
        {5'd11, 1'b0, 1'b1, 16'h5000, 1'b0, 1'b1}, // R11
        {5'd4 , 1'b1, 1'b0, 16'h8000, 1'b0, 1'b1}, // R4
        {5'd2 , 1'b0, 1'b0, 16'h1000, 1'b0, 1'b1}, // R2
        {5'd3 , 1'b0, 1'b1, 16'h5000, 1'b0, 1'b1}, // R3 not yet on
        {5'd3 , 1'b0, 1'b1, 16'h1000, 1'b1, 1'b0}, // R3 on now
        {5'd7 , 1'b0, 1'b1, 16'h7FFF, 1'b1, 1'b0}, // R7
        {5'd6 , 1'b1, 1'b1, 16'hC000, 1'b0, 1'b1}, // R6 priv lower bound fetch
        {5'd6 , 1'b0, 1'b1, 16'h4000, 1'b0, 1'b1}, // R6
        {5'd9 , 1'b1, 1'b1, 16'h2000, 1'b1, 1'b0}, // R9 fetch later discarded
        {5'd9 , 1'b0, 1'b1, 16'h01FF, 1'b1, 1'b0}, // R9 stack push
        {5'd9 , 1'b0, 1'b1, 16'h01FE, 1'b1, 1'b0}, // R9 stack push
        {5'd9 , 1'b0, 1'b1, 16'h5000, 1'b1, 1'b0}, // R9 flag cleared by it
        {5'd9 , 1'b1, 1'b1, 16'hF800, 1'b0, 1'b1}, // R9 handler fetch
        {5'd9 , 1'b0, 1'b1, 16'h5000, 1'b0, 1'b1}  // R9 handler privileged
    };

    task automatic check(input int req, input logic ef, input logic es);
        checks++;
        if (fast_cs !== ef || slow_cs !== es) begin
            errors++;
            $display("FAIL R%0d addr=%h fast/slow=%b%b expected %b%b",
                     req, addr, fast_cs, slow_cs, ef, es);
        end
        if (!rst) begin
            checks++;
            if ((fast_cs ^ slow_cs) !== 1'b1) begin // R10
                errors++;
                $display("FAIL R10 fast/slow=%b%b expected one-hot", fast_cs, slow_cs);
            end
        end
    endtask

    task automatic apply(input logic f, input logic s, input logic [15:0] a);
        @(negedge clk);
        opf = f; shen = s; addr = a;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        rst = 1'b1; opf = 1'b0; shen = 1'b0; addr = '0;
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        check(1, 1'b0, 1'b0); // R1 quiet in reset
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            if (i != 0) @(negedge clk);
            opf = VEC[i][19]; shen = VEC[i][18]; addr = VEC[i][17:2];
            #(CLK_PERIOD/4);
            check(int'(VEC[i][24:20]), VEC[i][1], VEC[i][0]);
        end
        // R1: reset with flag and shadow both set
        @(negedge clk);
        rst = 1'b1; opf = 1'b0; shen = 1'b1; addr = 16'h5000;
        #(CLK_PERIOD/4);
        check(1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        check(1, 1'b0, 1'b1); // shadow cleared
        apply(1'b0, 1'b1, 16'h5000);
        check(1, 1'b1, 1'b0); // flag cleared
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule